// File: doc/BRIEF.md
# Prescaled Software Watchdog Timer

This block watches for periodic servicing by software and raises a one-cycle reset request if that servicing stops. Counting runs only while the enable input is high. Each service strobe clears all counting state and starts a new timeout interval. If no service arrives within the interval, the block issues a single-cycle `bite` pulse and begins the next interval from zero.

Two controls set the timeout. The first is a one-bit prescale select, which places a fixed divide-by-2^`PRE_W` stage (512 by default) in front of the main counter. The second is a two-bit span code, which sets the main counter's length to 2^(`BASE_EXP` + 2·code) counts. Together they give eight power-of-two ratios, counted in system clocks. With the default parameters these are 2^9, 2^11, 2^13 and 2^15 without the prescale stage, and 2^18, 2^20, 2^22 and 2^24 with it.

The block captures both controls only while it is disabled, so software cannot shorten or lengthen an interval that is already running.

Top module: `swdog_timer`

## Requirements
- R1: During and after reset, `bite` is 0 and the counters are zero. The captured configuration is prescale off with span code 00, so an enable raised straight out of reset gives the shortest ratio.
- R2: With prescale select 0, span codes 00, 01, 10 and 11 give a timeout of 2^(BASE_EXP), 2^(BASE_EXP+2), 2^(BASE_EXP+4) and 2^(BASE_EXP+6) clocks. With the defaults these are 2^9, 2^11, 2^13 and 2^15.
- R3: With prescale select 1, each ratio from R2 is multiplied by 2^PRE_W. With the defaults these are 2^18, 2^20, 2^22 and 2^24.
- R4: Take N as the selected ratio. If `en` is high and `svc` is low for N consecutive rising edges, `bite` is high for exactly the one cycle after the N-th edge. Counting then restarts, so unserviced timeouts repeat every N clocks.
- R5: A `svc` strobe sampled with `en` high clears both the prescaler and the main counter. The next `bite` follows N further unserviced enabled edges after the service edge.
- R6: A `svc` strobe on the edge that would complete the interval takes priority. No `bite` results from that edge.
- R7: While `en` is low, the counters hold at zero and `bite` stays 0.
- R8: `pre_sel` and `span_sel` are captured on every edge where `en` is low, and only on those edges. Changes made while `en` is high have no effect until `en` has been low for at least one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Watchdog enable; counting runs only while high |
| svc | input | 1 | Service strobe; restarts the interval |
| pre_sel | input | 1 | Prescale select (1 = divide by 2^PRE_W first) |
| span_sel | input | 2 | Span code choosing the main counter length |
| bite | output | 1 | Registered one-cycle reset request on timeout |

## Verification
The checker covers properties that hold on every cycle:
- a `bite` lasts a single cycle and leaves the counter at zero;
- a disabled cycle produces no `bite` and leaves a zero count;
- a service never produces a `bite` on the following cycle;
- the count never passes the terminal value.

The exact timeout length for each of the eight prescale and span combinations can only be shown by the bench's scenarios. The same holds for the restart after a mid-interval service (including one that lands partway through a prescale period), the priority of a service that coincides with terminal count, and the rule that configuration written while enabled is ignored until a disable.

// File: rtl/swdog_timer.sv
module swdog_timer #(
  parameter int PRE_W    = 9,
  parameter int BASE_EXP = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       svc,
  input  logic       pre_sel,
  input  logic [1:0] span_sel,
  output logic       bite
);
  localparam int CNT_W = BASE_EXP + 6;

  logic             cfg_pre;
  logic [1:0]       cfg_span;
  logic [PRE_W-1:0] pcnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;
  logic             tick;
  logic             at_term;
  logic             expire;

  assign term    = {CNT_W{1'b1}} >> {~cfg_span, 1'b0};
  assign tick    = ~cfg_pre | (&pcnt);
  assign at_term = tick & (cnt == term);
  assign expire  = en & ~svc & at_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_pre  <= 1'b0;
      cfg_span <= 2'b00;
      pcnt     <= '0;
      cnt      <= '0;
      bite     <= 1'b0;
    end else begin
      bite <= expire;
      if (!en) begin
        cfg_pre  <= pre_sel;
        cfg_span <= span_sel;
        pcnt     <= '0;
        cnt      <= '0;
      end else if (svc) begin
        pcnt <= '0;
        cnt  <= '0;
      end else begin
        if (cfg_pre) pcnt <= pcnt + 1'b1;
        if (tick)    cnt  <= at_term ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

module swdog_timer_chk #(
  parameter int W = 15
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         svc,
  input logic         bite,
  input logic [W-1:0] cnt,
  input logic [W-1:0] term
);
  AST_BITE_SINGLE: assert property (@(posedge clk) disable iff (rst) bite |=> !bite); // R4
  AST_BITE_RESTART: assert property (@(posedge clk) disable iff (rst) bite |-> cnt == '0); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= term); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !en |=> (!bite && cnt == '0)); // R7
  AST_SVC_WINS: assert property (@(posedge clk) disable iff (rst) (en && svc) |=> !bite); // R6
endmodule

bind swdog_timer swdog_timer_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .svc(svc), .bite(bite), .cnt(cnt), .term(term)
);

// File: tb/swdog_timer_tb.sv
module swdog_timer_tb;
  localparam int PB = 3;
  localparam int BB = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       svc = 1'b0;
  logic       pre_sel = 1'b0;
  logic [1:0] span_sel = 2'b00;
  logic       bite;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  swdog_timer #(.PRE_W(PB), .BASE_EXP(BB)) u_dut (
    .clk(clk), .rst(rst), .en(en), .svc(svc),
    .pre_sel(pre_sel), .span_sel(span_sel), .bite(bite)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic int ratio(input logic p, input logic [1:0] s);
    return 1 << (BB + 2 * int'(s) + (p ? PB : 0));
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      tick();
      chk(req, bite, 1'b0);
    end
  endtask

  task automatic disable_with(input logic p, input logic [1:0] s);
    en = 1'b0; pre_sel = p; span_sel = s;
    tick();
    chk("R7", bite, 1'b0);
  endtask

  initial begin
    int n;
    @(negedge clk);
    pre_sel = 1'b1; span_sel = 2'b11; en = 1'b1;
    tick(); tick();
    chk("R1", bite, 1'b0);
    rst = 1'b0;
    n = ratio(1'b0, 2'b00);
    quiet(n - 1, "R1");
    tick(); chk("R1", bite, 1'b1);
    tick(); chk("R4", bite, 1'b0);

    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 4; s++) begin
        disable_with(p[0], s[1:0]);
        en = 1'b1;
        n = ratio(p[0], s[1:0]);
        quiet(n - 1, p ? "R3" : "R2");
        tick(); chk(p ? "R3" : "R2", bite, 1'b1);
        quiet(n - 1, "R4");
        tick(); chk("R4", bite, 1'b1);
        tick(); chk("R4", bite, 1'b0);
      end
    end

    disable_with(1'b0, 2'b01);
    en = 1'b1; n = ratio(1'b0, 2'b01);
    quiet(10, "R5");
    svc = 1'b1; tick(); svc = 1'b0; chk("R5", bite, 1'b0);
    quiet(n - 1, "R5");
    tick(); chk("R5", bite, 1'b1);

    disable_with(1'b1, 2'b00);
    en = 1'b1; n = ratio(1'b1, 2'b00);
    quiet(5, "R5");
    svc = 1'b1; tick(); svc = 1'b0;
    quiet(n - 1, "R5");
    tick(); chk("R5", bite, 1'b1);

    disable_with(1'b0, 2'b00);
    en = 1'b1; n = ratio(1'b0, 2'b00);
    quiet(n - 1, "R6");
    svc = 1'b1; tick(); svc = 1'b0; chk("R6", bite, 1'b0);
    quiet(n - 1, "R6");
    tick(); chk("R6", bite, 1'b1);

    disable_with(1'b0, 2'b00);
    en = 1'b1;
    pre_sel = 1'b1; span_sel = 2'b11;
    quiet(ratio(1'b0, 2'b00) - 1, "R8");
    tick(); chk("R8", bite, 1'b1);
    en = 1'b0;
    quiet(20, "R7");
    en = 1'b1; n = ratio(1'b1, 2'b11);
    quiet(n - 1, "R8");
    tick(); chk("R8", bite, 1'b1);

    en = 1'b0;
    quiet(3, "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule